// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block burns one one-time-programmable fuse word per request. A register front-end pulses a start input, presenting the target word address, the new data and a packed timing word. The sequencer first reads the word as it stands in the fuse array. It clears from the new data every bit that is already blown, so that no fuse is ever struck twice. It then walks the masked word serially. The least significant bit goes first, and the working register shifts right with zero fill.

Each 1 bit receives a timed program strobe, with a quiet gap on either side. Each 0 bit costs a single cycle and produces no strobe. After all word positions have been visited, the block holds off for a fixed post-write interval that protects the array. It then issues a one-cycle done pulse and returns to idle. The timing counts arrive precomputed from the clock rate. Only the post-write interval is a build-time cycle count.

Top module: `fuse_prog_seq`

## Requirements
- R1: A start pulse seen while idle latches address, data and timing and raises busy_o in the next cycle. A start pulse while busy_o is high (including the done cycle) has no effect on the running operation and launches no second one.
- R2: The timing word is decoded as follows: program strobe length in bits [11:0], gap count in bits [15:12], read strobe length in bits [21:16]. A strobe length of 0 is treated as 1 cycle. Every gap lasts gap count + 1 cycles.
- R3: After start, the block waits one gap. It then asserts fuse_rd_o for the read strobe length, with fuse_addr_o at the latched address. The fuse contents are taken in the last cycle of that strobe.
- R4: The word that is programmed is the new data ANDed with the inverse of the word read, so an already-blown bit is never struck again.
- R5: Bit positions are visited in ascending order, bit 0 first. fuse_bit_o names the position under the strobe. A 0 bit takes exactly one cycle and raises no strobe.
- R6: A 1 bit takes one decision cycle, then a gap, then fuse_pgm_o high for the program strobe length, then a gap.
- R7: The serial phase ends after exactly WORD_W positions. It is followed by POST_CYCLES quiet cycles with both strobes low.
- R8: done_o is a one-cycle pulse in the cycle after the quiet interval expires, and busy_o falls one cycle later. With no strobes clamped, the start-to-done delay is gap + read length + the sum of the per-bit costs + POST_CYCLES.
- R9: fuse_rd_o and fuse_pgm_o are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse |
| addr_i | input | ADDR_W | Target fuse word address |
| data_i | input | WORD_W | Data to program (1 = blow) |
| tmg_i | input | 22 | Packed timing counts |
| fuse_rdata_i | input | WORD_W | Fuse word contents while reading |
| fuse_addr_o | output | ADDR_W | Address presented to the array |
| fuse_bit_o | output | $clog2(WORD_W) | Bit position being programmed |
| fuse_rd_o | output | 1 | Read strobe |
| fuse_pgm_o | output | 1 | Program strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle: the two strobes are mutually exclusive, nothing toggles while idle, done lasts one cycle and occurs only while busy, and the address and bit index hold steady through an operation and a strobe. The directed scenarios show the behaviours that depend on data and timing. These are the read-before-write masking against preblown words, the ascending bit order, the exact strobe and gap lengths, the clamping of zero strobe counts, the exact start-to-done latency, and the rejection of a second request during an operation.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int TMG_W      = 22;
  localparam int PGM_LEN_W  = 12;
  localparam int GAP_W      = 4;
  localparam int RD_LEN_W   = 6;

  typedef struct packed {
    logic [RD_LEN_W-1:0]  rd_len;
    logic [GAP_W-1:0]     gap;
    logic [PGM_LEN_W-1:0] pgm_len;
  } fps_tmg_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RSET, ST_RSTB, ST_BIT, ST_PRE,
    ST_PGM, ST_POST, ST_QUIET, ST_DONE
  } fps_state_e;
endpackage

// File: rtl/fps_tmg_decode.sv
module fps_tmg_decode
  import fps_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [TMG_W-1:0] tmg_i,
  output logic [CNT_W-1:0] pgm_len_o,
  output logic [CNT_W-1:0] rd_len_o,
  output logic [CNT_W-1:0] gap_len_o
);
  fps_tmg_t f;
  assign f = fps_tmg_t'(tmg_i);

  always_comb begin
    pgm_len_o = (f.pgm_len == '0) ? CNT_W'(1) : CNT_W'(f.pgm_len);
    rd_len_o  = (f.rd_len == '0)  ? CNT_W'(1) : CNT_W'(f.rd_len);
    gap_len_o = CNT_W'(f.gap) + CNT_W'(1);
  end
endmodule

// File: rtl/fps_phase_timer.sv
module fps_phase_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fps_shift_unit.sv
module fps_shift_unit #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              mask_i,
  input  logic [WORD_W-1:0] blown_i,
  input  logic              shift_i,
  output logic              lsb_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_bit_o
);
  logic [WORD_W-1:0] sreg_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      sreg_q <= data_i;
      idx_q  <= '0;
    end else if (mask_i) begin
      sreg_q <= sreg_q & ~blown_i;
    end else if (shift_i) begin
      sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign lsb_o      = sreg_q[0];
  assign idx_o      = idx_q;
  assign last_bit_o = (idx_q == IDX_W'(WORD_W - 1));
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int ADDR_W      = 7,
  parameter int POST_CYCLES = 500,
  localparam int IDX_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [TMG_W-1:0]  tmg_i,
  input  logic [WORD_W-1:0] fuse_rdata_i,
  output logic [ADDR_W-1:0] fuse_addr_o,
  output logic [IDX_W-1:0]  fuse_bit_o,
  output logic              fuse_rd_o,
  output logic              fuse_pgm_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int POST_W   = $clog2(POST_CYCLES + 2);
  localparam int CNT_W    = (POST_W > PGM_LEN_W) ? POST_W : PGM_LEN_W;
  localparam int POST_LEN = (POST_CYCLES < 1) ? 1 : POST_CYCLES;

  fps_state_e st_q, st_d;

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  pgm_len_d, rd_len_d, gap_len_d;
  logic [CNT_W-1:0]  pgm_len_q, rd_len_q, gap_len_q;
  logic              t_load, t_last;
  logic [CNT_W-1:0]  t_val;
  logic              accept, do_mask, do_shift;
  logic              lsb, last_bit;
  logic [IDX_W-1:0]  bit_idx;

  fps_tmg_decode #(.CNT_W(CNT_W)) u_dec (
    .tmg_i     (tmg_i),
    .pgm_len_o (pgm_len_d),
    .rd_len_o  (rd_len_d),
    .gap_len_o (gap_len_d)
  );

  fps_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (t_load),
    .load_val_i (t_val),
    .last_o     (t_last)
  );

  fps_shift_unit #(.WORD_W(WORD_W)) u_shf (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .data_i     (data_i),
    .mask_i     (do_mask),
    .blown_i    (fuse_rdata_i),
    .shift_i    (do_shift),
    .lsb_o      (lsb),
    .idx_o      (bit_idx),
    .last_bit_o (last_bit)
  );

  always_comb begin
    st_d     = st_q;
    t_load   = 1'b0;
    t_val    = '0;
    accept   = 1'b0;
    do_mask  = 1'b0;
    do_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        accept = 1'b1;
        t_load = 1'b1;
        t_val  = gap_len_d;
        st_d   = ST_RSET;
      end
      ST_RSET: if (t_last) begin
        t_load = 1'b1;
        t_val  = rd_len_q;
        st_d   = ST_RSTB;
      end
      ST_RSTB: if (t_last) begin
        do_mask = 1'b1;
        st_d    = ST_BIT;
      end
      ST_BIT: begin
        if (lsb) begin
          t_load = 1'b1;
          t_val  = gap_len_q;
          st_d   = ST_PRE;
        end else begin
          do_shift = 1'b1;
          if (last_bit) begin
            t_load = 1'b1;
            t_val  = CNT_W'(POST_LEN);
            st_d   = ST_QUIET;
          end
        end
      end
      ST_PRE: if (t_last) begin
        t_load = 1'b1;
        t_val  = pgm_len_q;
        st_d   = ST_PGM;
      end
      ST_PGM: if (t_last) begin
        t_load = 1'b1;
        t_val  = gap_len_q;
        st_d   = ST_POST;
      end
      ST_POST: if (t_last) begin
        do_shift = 1'b1;
        if (last_bit) begin
          t_load = 1'b1;
          t_val  = CNT_W'(POST_LEN);
          st_d   = ST_QUIET;
        end else begin
          st_d = ST_BIT;
        end
      end
      ST_QUIET: if (t_last) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      pgm_len_q <= '0;
      rd_len_q  <= '0;
      gap_len_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q    <= addr_i;
        pgm_len_q <= pgm_len_d;
        rd_len_q  <= rd_len_d;
        gap_len_q <= gap_len_d;
      end
    end
  end

  assign fuse_addr_o = addr_q;
  assign fuse_bit_o  = bit_idx;
  assign fuse_rd_o   = (st_q == ST_RSTB);
  assign fuse_pgm_o  = (st_q == ST_PGM);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fuse_addr_o,
  input logic [IDX_W-1:0]  fuse_bit_o,
  input logic              fuse_rd_o,
  input logic              fuse_pgm_o,
  input logic              busy_o,
  input logic              done_o
);
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(fuse_rd_o && fuse_pgm_o));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!fuse_rd_o && !fuse_pgm_o && !done_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !busy_o));

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o));

  p_bit_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (fuse_pgm_o && $past(fuse_pgm_o)) |-> $stable(fuse_bit_o));

  p_rd_before_pgm_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(fuse_rd_o) |-> !fuse_pgm_o);
endmodule

bind fuse_prog_seq fps_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fps_chk (
  .clk         (clk),
  .rst         (rst),
  .fuse_addr_o (fuse_addr_o),
  .fuse_bit_o  (fuse_bit_o),
  .fuse_rd_o   (fuse_rd_o),
  .fuse_pgm_o  (fuse_pgm_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/fuse_prog_seq_test.sv
module fuse_prog_seq_test;
  localparam int POST = 500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] data_i = '0;
  logic [21:0] tmg_i = '0;
  logic [31:0] fuse_rdata_i;
  logic [6:0]  fuse_addr_o;
  logic [4:0]  fuse_bit_o;
  logic        fuse_rd_o, fuse_pgm_o, busy_o, done_o;

  always #2 clk = ~clk;

  fuse_prog_seq #(.WORD_W(32), .ADDR_W(7), .POST_CYCLES(POST)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .data_i(data_i), .tmg_i(tmg_i), .fuse_rdata_i(fuse_rdata_i),
    .fuse_addr_o(fuse_addr_o), .fuse_bit_o(fuse_bit_o),
    .fuse_rd_o(fuse_rd_o), .fuse_pgm_o(fuse_pgm_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  logic [31:0] fmem [0:127];
  assign fuse_rdata_i = fuse_rd_o ? fmem[fuse_addr_o] : 32'hA5A5_5A5A;

  int checks = 0, failures = 0;
  int cyc = 0;
  int npulse, pw, rd_rise, rd_w, ndone, done_cyc, c0;
  int rise_t [0:39];
  int bit_s  [0:39];
  int wid_s  [0:39];
  bit pgm_prev = 0, rd_prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (fuse_pgm_o) begin
      if (!pgm_prev) begin
        rise_t[npulse] = cyc;
        bit_s[npulse]  = fuse_bit_o;
        pw = 0;
      end
      pw = pw + 1;
      fmem[fuse_addr_o][fuse_bit_o] = 1'b1;
    end else if (pgm_prev) begin
      wid_s[npulse] = pw;
      npulse = npulse + 1;
    end
    if (fuse_rd_o) begin
      if (!rd_prev) begin rd_rise = cyc; rd_w = 0; end
      rd_w = rd_w + 1;
    end
    if (done_o) begin done_cyc = cyc; ndone = ndone + 1; end
    pgm_prev = fuse_pgm_o;
    rd_prev  = fuse_rd_o;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] mk_tmg(int s, int r, int rd);
    return {rd[5:0], r[3:0], s[11:0]};
  endfunction

  task automatic launch(input logic [6:0] a, input logic [31:0] d, input logic [21:0] t);
    npulse = 0; ndone = 0; done_cyc = -1; rd_rise = -1; rd_w = 0;
    @(negedge clk);
    start_i = 1'b1; addr_i = a; data_i = d; tmg_i = t;
    c0 = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 30000 && ndone == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // full check of one operation against the requirement model
  task automatic run_and_check(input string tag, input logic [6:0] a,
                               input logic [31:0] old, input logic [31:0] d,
                               input int s, input int r, input int rd);
    logic [31:0] m;
    int sl, rl, total, k, first;
    fmem[a] = old;
    m  = d & ~old;
    sl = (s == 0) ? 1 : s;
    rl = (rd == 0) ? 1 : rd;
    total = (r + 1) + rl + POST;
    first = -1;
    for (int b = 0; b < 32; b++) begin
      if (m[b]) begin
        total += 1 + 2 * (r + 1) + sl;
        if (first < 0) first = b;
      end else total += 1;
    end
    launch(a, d, mk_tmg(s, r, rd));
    wait_done();
    chk("R4", {tag, " final fuse word"}, fmem[a], old | d);
    chk("R4", {tag, " strobe count"}, npulse, $countones(m));
    chk("R3", {tag, " read start"}, rd_rise, c0 + r + 1);
    chk("R3", {tag, " read width"}, rd_w, rl);
    chk("R8", {tag, " start-to-done"}, done_cyc - c0, total);
    chk("R8", {tag, " single done"}, ndone, 1);
    chk("R8", {tag, " busy after done"}, busy_o, 0);
    if (first >= 0)
      chk("R6", {tag, " first strobe time"}, rise_t[0], c0 + (r + 1) + rl + first + 1 + (r + 1));
    k = 0;
    for (int b = 0; b < 32; b++) begin
      if (m[b] && k < npulse) begin
        chk("R5", {tag, " strobe bit order"}, bit_s[k], b);
        chk("R6", {tag, " strobe width"}, wid_s[k], sl);
        k++;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy after reset", busy_o, 0);
    chk("R8", "done after reset", done_o, 0);
    chk("R9", "read strobe after reset", fuse_rd_o, 0);
    chk("R9", "program strobe after reset", fuse_pgm_o, 0);
  endtask

  task automatic t_basic();   run_and_check("R5 basic", 7'd3, 32'h0, 32'h0000_0005, 3, 1, 2); endtask
  task automatic t_mask();    run_and_check("R4 mask", 7'd10, 32'hF0F0_00FF, 32'hFFFF_0F0F, 2, 2, 3); endtask
  task automatic t_zero();    run_and_check("R5 zero", 7'd20, 32'h1234_5678, 32'h0, 4, 3, 5); endtask
  task automatic t_ones();    run_and_check("R7 ones", 7'd127, 32'h0, 32'hFFFF_FFFF, 1, 0, 1); endtask
  task automatic t_msb();     run_and_check("R7 msb", 7'd64, 32'h0, 32'h8000_0000, 5, 1, 2); endtask
  task automatic t_clamp();   run_and_check("R2 clamp", 7'd5, 32'h0, 32'h0000_0102, 0, 0, 0); endtask
  task automatic t_relax();   run_and_check("R2 maxgap", 7'd6, 32'h0000_0001, 32'h0000_0003, 7, 15, 63); endtask
  task automatic t_already(); run_and_check("R4 blown", 7'd7, 32'hFFFF_FFFF, 32'hAAAA_5555, 3, 1, 1); endtask

  task automatic t_ignore();
    fmem[7'd40] = 32'h0;
    fmem[7'd41] = 32'h0;
    launch(7'd40, 32'h0000_0011, mk_tmg(3, 1, 2));
    repeat (20) @(negedge clk);
    start_i = 1'b1; addr_i = 7'd41; data_i = 32'hFFFF_0000; tmg_i = mk_tmg(9, 4, 9);
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk("R1", "first word programmed", fmem[7'd40], 32'h0000_0011);
    chk("R1", "ignored request left word untouched", fmem[7'd41], 32'h0);
    chk("R1", "strobes of ignored request", npulse, 2);
    chk("R1", "idle after single op", busy_o, 0);
    chk("R1", "strobe width unaffected", wid_s[1], 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) fmem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_zero();
    t_ones();
    t_msb();
    t_clamp();
    t_relax();
    t_already();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule